// File: doc/BRIEF.md
# Audio Sample-Path Interrupt Status Register

This block records the handoff events of a small audio interface that has one receive (microphone) channel and one transmit (speaker) channel. It holds the most recent converter sample for the CPU and the next sample for the output converter, and keeps a data-valid flag for each. From these it detects three events: a receive overrun, where a new input sample replaces one the CPU has not read; a receive completion, where a sample lands in the DMA receive holding register; and a transmit underrun (mute), where the output converter fetches while no valid sample is waiting.

Each event latches a sticky flag in a 16-bit status register, and the interrupt output is high while any flag is set. Software clears a flag by writing 1 to its bit. The underrun flag is gated by an arming latch. The latch arms only when the transmit channel is enabled and a valid sample has been present. It disarms as soon as the enable drops. This keeps an idle or freshly enabled channel from reporting mute.

Top module: `snd_irq_status`

## Requirements
- R1: Address 0 reads the status word: bit 9 is receive overrun, bit 8 is receive completion and bit 1 is transmit underrun. All other bits read 0, and writing to them has no effect.
- R2: A set flag stays set until software writes 1 to its bit at address 0. Writing 0 to the bit leaves the flag unchanged.
- R3: After reset, the status word, both data-valid flags, the receive data word and irq_o are all 0.
- R4: If an input sample arrives while the receive valid flag is 1, and address 1 is not being read with bus_re_i in the same cycle, the overrun flag sets. The new sample replaces the held one, and address 1 returns it.
- R5: A pulse on dma_rx_wr_i sets the completion flag on the next edge.
- R6: A fetch on dac_take_i while the transmit valid flag is 0 sets the underrun flag only if the channel is armed. The channel arms one edge after tx_en_i is 1 with the transmit valid flag at 1, and it stays armed while tx_en_i stays high.
- R7: When a hardware set and a software write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: The receive valid flag sets on each sample arrival and clears on a bus read of address 1 with bus_re_i. The transmit valid flag sets on a bus write to address 2 and clears when dac_take_i fetches. Address 3 reads the receive valid flag in bit 0 and the transmit valid flag in bit 1, with all other bits 0.
- R9: irq_o is 1 exactly when the status word is nonzero.
- R10: Dropping tx_en_i for one cycle disarms the channel. After re-enable, fetches do not report underrun until a new valid sample has been written.
- R11: dac_data_o carries the sample last written to address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_strobe_i | input | 1 | Input converter sample arrival |
| adc_data_i | input | SAMPLE_W | Arriving input sample |
| dma_rx_wr_i | input | 1 | Sample written into DMA receive holding register |
| dac_take_i | input | 1 | Output converter fetches a sample |
| tx_en_i | input | 1 | Transmit channel enable |
| dac_data_o | output | SAMPLE_W | Transmit sample held for the output converter |
| bus_addr_i | input | ADDR_W | Register address: 0 status, 1 receive data, 2 transmit data, 3 valid flags |
| bus_we_i | input | 1 | Single-cycle write strobe |
| bus_re_i | input | 1 | Read strobe; a read of address 1 consumes the receive sample |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Interrupt request, high while any flag is set |

## Verification
The hardest case to reach is a set and a clear landing on the same flag in one cycle. The underrun case is the worst, because it needs an armed channel with an empty transmit register. The stimulus gets there by enabling the channel, writing a sample, and letting two fetches drain it. It then pulses the fetch in the same cycle as a write-1 clear. A sweep over all 16 write-data bits, each applied with all three flags set, then shows that each clear hits only its own bit.

// File: rtl/snd_irq_pkg.sv
package snd_irq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_STAT = 0;
  localparam int ADDR_RXD  = 1;
  localparam int ADDR_TXD  = 2;
  localparam int ADDR_VLD  = 3;
  localparam int FLAG_N    = 3;
  // flag index: 0 underrun, 1 completion, 2 overrun
  localparam int IDX_UND   = 0;
  localparam int IDX_DONE  = 1;
  localparam int IDX_OVR   = 2;

  function automatic int flag_pos(input int idx);
    case (idx)
      IDX_UND:  return 1;
      IDX_DONE: return 8;
      default:  return 9;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] flag_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < FLAG_N; i++) m[flag_pos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/snd_sticky_flag.sv
module snd_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= 1'b0;
    else if (set_i)    q_q <= 1'b1; // set beats clear
    else if (clr_i)    q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/snd_rx_hold.sv
module snd_rx_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arrive_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                pop_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                overrun_o
);
  logic                vld_q;
  logic [SAMPLE_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (arrive_i) begin
        vld_q <= 1'b1;
        dat_q <= data_i; // overwrite held sample
      end else if (pop_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  // same-cycle pop means the held sample was read, not lost
  assign overrun_o = arrive_i & vld_q & ~pop_i;
  assign valid_o   = vld_q;
  assign data_o    = dat_q;
endmodule

// File: rtl/snd_tx_hold.sv
module snd_tx_hold #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                take_i,
  input  logic                en_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] data_o,
  output logic                armed_o,
  output logic                underrun_o
);
  logic                vld_q;
  logic                arm_q;
  logic [SAMPLE_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      if (load_i) begin
        vld_q <= 1'b1;
        dat_q <= data_i;
      end else if (take_i) begin
        vld_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= en_i & (arm_q | vld_q);
  end

  assign underrun_o = take_i & ~vld_q & arm_q;
  assign valid_o    = vld_q;
  assign data_o     = dat_q;
  assign armed_o    = arm_q;
endmodule

// File: rtl/snd_irq_status.sv
module snd_irq_status
  import snd_irq_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                adc_strobe_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  input  logic                dma_rx_wr_i,
  input  logic                dac_take_i,
  input  logic                tx_en_i,
  output logic [SAMPLE_W-1:0] dac_data_o,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_we_i,
  input  logic                bus_re_i,
  input  logic [REG_W-1:0]    bus_wdata_i,
  output logic [REG_W-1:0]    bus_rdata_o,
  output logic                irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(ADDR_RXD);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(ADDR_TXD);
  localparam logic [ADDR_W-1:0] A_VLD  = ADDR_W'(ADDR_VLD);

  logic                wr_stat, wr_txd, rd_rxd;
  logic                rx_vld, tx_vld, und_arm;
  logic                ovr_evt, und_evt;
  logic [SAMPLE_W-1:0] rx_data;
  logic [FLAG_N-1:0]   flag_set, flag_clr, flag_q;
  logic [REG_W-1:0]    stat_word;

  assign wr_stat = bus_we_i & (bus_addr_i == A_STAT);
  assign wr_txd  = bus_we_i & (bus_addr_i == A_TXD);
  assign rd_rxd  = bus_re_i & (bus_addr_i == A_RXD);

  snd_rx_hold #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arrive_i  (adc_strobe_i),
    .data_i    (adc_data_i),
    .pop_i     (rd_rxd),
    .valid_o   (rx_vld),
    .data_o    (rx_data),
    .overrun_o (ovr_evt)
  );

  snd_tx_hold #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_txd),
    .data_i     (bus_wdata_i[SAMPLE_W-1:0]),
    .take_i     (dac_take_i),
    .en_i       (tx_en_i),
    .valid_o    (tx_vld),
    .data_o     (dac_data_o),
    .armed_o    (und_arm),
    .underrun_o (und_evt)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[IDX_UND]  = und_evt;
    flag_set[IDX_DONE] = dma_rx_wr_i;
    flag_set[IDX_OVR]  = ovr_evt;
  end

  for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
    assign flag_clr[g] = wr_stat & bus_wdata_i[flag_pos(g)];
    snd_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flag_set[g]),
      .clr_i  (flag_clr[g]),
      .q_o    (flag_q[g])
    );
  end

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < FLAG_N; i++) stat_word[flag_pos(i)] = flag_q[i];
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      A_STAT:  bus_rdata_o = stat_word;
      A_RXD:   bus_rdata_o = REG_W'(rx_data);
      A_VLD:   bus_rdata_o = REG_W'({tx_vld, rx_vld});
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = |flag_q;
endmodule

// File: rtl/snd_irq_status_chk.sv
module snd_irq_status_chk
  import snd_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              adc_strobe_i,
  input logic              dma_rx_wr_i,
  input logic              dac_take_i,
  input logic              tx_en_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic              bus_re_i,
  input logic [REG_W-1:0]  bus_wdata_i,
  input logic [REG_W-1:0]  bus_rdata_o,
  input logic              irq_o,
  input logic [FLAG_N-1:0] flag_q,
  input logic              rx_vld,
  input logic              tx_vld,
  input logic              und_arm
);
  logic at_stat, at_rxd, at_txd;
  assign at_stat = (bus_addr_i == ADDR_W'(ADDR_STAT));
  assign at_rxd  = (bus_addr_i == ADDR_W'(ADDR_RXD));
  assign at_txd  = (bus_addr_i == ADDR_W'(ADDR_TXD));

  p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_stat |-> ((bus_rdata_o & ~flag_mask()) == '0));

  for (genvar g = 0; g < FLAG_N; g++) begin : g_sticky
    p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !(bus_we_i && at_stat && bus_wdata_i[flag_pos(g)])) |=> flag_q[g]);
  end

  p_overrun_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_strobe_i && rx_vld && !(bus_re_i && at_rxd)) |=> flag_q[IDX_OVR]);

  p_done_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_rx_wr_i |=> flag_q[IDX_DONE]);

  p_underrun_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!und_arm && !flag_q[IDX_UND]) |=> !flag_q[IDX_UND]);

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dac_take_i && !tx_vld && und_arm) |=> flag_q[IDX_UND]);

  p_tx_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && at_txd) |=> tx_vld);

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_stat |-> (irq_o == (bus_rdata_o != '0)));

  p_disarm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !und_arm);
endmodule

bind snd_irq_status snd_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adc_strobe_i (adc_strobe_i),
  .dma_rx_wr_i  (dma_rx_wr_i),
  .dac_take_i   (dac_take_i),
  .tx_en_i      (tx_en_i),
  .bus_addr_i   (bus_addr_i),
  .bus_we_i     (bus_we_i),
  .bus_re_i     (bus_re_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .irq_o        (irq_o),
  .flag_q       (flag_q),
  .rx_vld       (rx_vld),
  .tx_vld       (tx_vld),
  .und_arm      (und_arm)
);

// File: tb/tb_snd_irq_status.sv
module tb_snd_irq_status;
  localparam int SW = 16;
  localparam int AW = 2;
  localparam logic [15:0] ALL = 16'h0302;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          adc_strobe_i = 1'b0;
  logic [SW-1:0] adc_data_i = '0;
  logic          dma_rx_wr_i = 1'b0;
  logic          dac_take_i = 1'b0;
  logic          tx_en_i = 1'b0;
  logic [SW-1:0] dac_data_o;
  logic [AW-1:0] bus_addr_i = '0;
  logic          bus_we_i = 1'b0;
  logic          bus_re_i = 1'b0;
  logic [15:0]   bus_wdata_i = '0;
  logic [15:0]   bus_rdata_o;
  logic          irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  snd_irq_status #(.SAMPLE_W(SW), .ADDR_W(AW)) dut (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_addr_i = AW'(a);
    #1;
    d = bus_rdata_o;
  endtask

  task automatic chk_reg(input string tag, input int a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_addr_i = AW'(a); bus_wdata_i = d; bus_we_i = 1'b1;
    tick();
    bus_we_i = 1'b0;
  endtask

  task automatic pop_rx();
    bus_addr_i = AW'(1); bus_re_i = 1'b1;
    tick();
    bus_re_i = 1'b0;
  endtask

  task automatic adc(input logic [15:0] s);
    adc_data_i = s; adc_strobe_i = 1'b1;
    tick();
    adc_strobe_i = 1'b0;
  endtask

  task automatic take();
    dac_take_i = 1'b1;
    tick();
    dac_take_i = 1'b0;
  endtask

  task automatic dma();
    dma_rx_wr_i = 1'b1;
    tick();
    dma_rx_wr_i = 1'b0;
  endtask

  // requires armed channel with empty transmit register
  task automatic set_all();
    dma();
    adc(16'h0055);
    adc(16'h00AA);
    take();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=%h exp=%h", 16'h0, 16'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] e;
    #2;
    // R3: reset state
    chk_reg("R3 status", 0, 16'h0000);
    chk_reg("R3 valid", 3, 16'h0000);
    chk_reg("R3 rxdata", 1, 16'h0000);
    chk("R3 irq", {15'b0, irq_o}, 16'h0000);
    #20 rst_ni = 1'b1;
    tick();

    // R5 / R9
    dma();
    chk_reg("R5 completion", 0, 16'h0100);
    chk("R9 irq set", {15'b0, irq_o}, 16'h0001);
    // R2
    wr(0, 16'h0000);
    chk_reg("R2 write0 keeps", 0, 16'h0100);
    wr(0, 16'h0100);
    chk_reg("R2 write1 clears", 0, 16'h0000);
    chk("R9 irq clear", {15'b0, irq_o}, 16'h0000);

    // R4 / R8 receive path
    adc(16'h1111);
    chk_reg("R8 rx valid", 3, 16'h0001);
    chk_reg("R4 no overrun yet", 0, 16'h0000);
    adc(16'h2222);
    chk_reg("R4 overrun", 0, 16'h0200);
    chk_reg("R4 overwrite", 1, 16'h2222);
    pop_rx();
    chk_reg("R8 rx pop clears", 3, 16'h0000);
    wr(0, 16'h0200);
    adc(16'h3333);
    bus_addr_i = AW'(1); bus_re_i = 1'b1; adc_data_i = 16'h4444; adc_strobe_i = 1'b1;
    tick();
    bus_re_i = 1'b0; adc_strobe_i = 1'b0;
    chk_reg("R4 same-cycle pop no overrun", 0, 16'h0000);
    chk_reg("R4 new sample held", 1, 16'h4444);
    chk_reg("R8 valid after arrival", 3, 16'h0001);
    pop_rx();

    // R6 / R11 transmit path
    take();
    chk_reg("R6 disabled no underrun", 0, 16'h0000);
    tx_en_i = 1'b1;
    tick();
    take();
    chk_reg("R6 unarmed no underrun", 0, 16'h0000);
    wr(2, 16'hABCD);
    chk_reg("R8 tx valid", 3, 16'h0002);
    chk("R11 dac data", dac_data_o, 16'hABCD);
    take();
    chk_reg("R8 take clears tx valid", 3, 16'h0000);
    chk_reg("R6 valid take no underrun", 0, 16'h0000);
    take();
    chk_reg("R6 armed underrun", 0, 16'h0002);
    wr(0, 16'h0002);

    // R10 disarm
    tx_en_i = 1'b0;
    tick();
    tx_en_i = 1'b1;
    tick();
    take();
    chk_reg("R10 disarmed after enable drop", 0, 16'h0000);
    wr(2, 16'h5A5A);
    chk("R11 dac data 2", dac_data_o, 16'h5A5A);
    take();
    take();
    chk_reg("R10 rearmed underrun", 0, 16'h0002);
    wr(0, 16'h0002);

    // R7 set beats clear
    take();
    dac_take_i = 1'b1; bus_addr_i = '0; bus_wdata_i = 16'h0002; bus_we_i = 1'b1;
    tick();
    dac_take_i = 1'b0; bus_we_i = 1'b0;
    chk_reg("R7 underrun set wins", 0, 16'h0002);
    wr(0, 16'hFFFF);
    dma_rx_wr_i = 1'b1; bus_addr_i = '0; bus_wdata_i = 16'h0100; bus_we_i = 1'b1;
    tick();
    dma_rx_wr_i = 1'b0; bus_we_i = 1'b0;
    chk_reg("R7 completion set wins", 0, 16'h0100);
    wr(0, 16'hFFFF);
    adc(16'h0001);
    adc_strobe_i = 1'b1; bus_addr_i = '0; bus_wdata_i = 16'h0200; bus_we_i = 1'b1;
    tick();
    adc_strobe_i = 1'b0; bus_we_i = 1'b0;
    chk_reg("R7 overrun set wins", 0, 16'h0200);
    wr(0, 16'hFFFF);

    // R1 / R2 sweep over every write-data bit
    for (int i = 0; i < 16; i++) begin
      set_all();
      chk_reg("R1 all flags", 0, ALL);
      wr(0, 16'h1 << i);
      e = ALL & ~(16'h1 << i);
      chk_reg("R1 bit clear sweep", 0, e);
      chk("R9 irq sweep", {15'b0, irq_o}, {15'b0, (e != 16'h0)});
      wr(0, 16'hFFFF);
      chk_reg("R2 clear all", 0, 16'h0000);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule